// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Permission Check

This block holds a small set of recently used page translations and searches all of them in parallel against the page number of an incoming virtual address. When a stored entry matches, the block joins that entry's physical page number to the untranslated page offset. In the same cycle it checks the access kind (read or write) and the privilege level (user or kernel) against the entry's flags. A lookup that finds no entry reports a miss. An external table walker then fetches the translation and writes it in through the refill port.

Each entry stores a valid flag, a read permission, a write permission, a dirty flag, a user-access flag, the virtual page tag and the physical page number. The slot that a new translation goes into comes from a replacement pointer, which is either a wrapping FIFO counter or a pseudo-random LFSR, chosen by a parameter. A single flush input invalidates every entry when the address space changes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss, and the replacement pointer points at slot 0.
- R2: A lookup that matches a valid entry and passes all checks raises `lk_hit_o` in the same cycle, with `lk_paddr_o` = {entry physical page, lower OFS_W bits of `lk_vaddr_i`}.
- R3: A lookup that matches no valid entry raises `lk_miss_o` only. `lk_paddr_o` is zero and both fault outputs stay low. With `lk_valid_i` low, all four outcome outputs are low.
- R4: A matching read to an entry with the read flag clear, or a matching write to an entry with the write flag clear, raises `lk_prot_fault_o` instead of a hit.
- R5: A user-mode lookup (`lk_user_i`=1) that matches an entry with the user flag clear raises `lk_prot_fault_o`. A kernel-mode lookup may use any valid entry that its access kind permits.
- R6: A matching write to an entry that has the write flag set and the dirty flag clear raises `lk_dirty_fault_o` instead of a hit. A protection fault takes precedence over a dirty fault.
- R7: A refill whose page number matches a valid entry overwrites that entry in place and does not move the replacement pointer.
- R8: In FIFO mode, a refill of a page number that is not present writes the slot under the pointer, and the pointer then advances by one modulo NUM_ENTRIES. The NUM_ENTRIES+1-th distinct refill therefore evicts the first one.
- R9: A flush invalidates every entry in one cycle and returns the FIFO pointer to slot 0. A refill presented in the same cycle as a flush is discarded.
- R10: A lookup in the same cycle as a refill sees the contents from before the refill. The new translation is visible from the next cycle.
- R11: At most one valid entry ever matches a given page number, and at most one outcome output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | VPN_W+OFS_W | Virtual address to translate |
| lk_write_i | input | 1 | 1 = write access, 0 = read access |
| lk_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit_o | output | 1 | Translation delivered |
| lk_miss_o | output | 1 | No matching entry |
| lk_prot_fault_o | output | 1 | Access denied by permission or privilege |
| lk_dirty_fault_o | output | 1 | Write to a clean writable page |
| lk_paddr_o | output | PPN_W+OFS_W | Physical address, zero unless hit |
| rf_valid_i | input | 1 | Refill write strobe |
| rf_vpn_i | input | VPN_W | Refill virtual page number |
| rf_ppn_i | input | PPN_W | Refill physical page number |
| rf_rd_i | input | 1 | Refill read permission |
| rf_wr_i | input | 1 | Refill write permission |
| rf_dirty_i | input | 1 | Refill dirty flag |
| rf_user_i | input | 1 | Refill user-access flag |

## Verification
A lookup and a refill can land in the same cycle. The interesting case is a refill that names the very page being looked up, or that rewrites its flags. The bench provokes this both in directed steps and in a random phase that draws page numbers from a small pool, so that collisions are frequent. The behavioural model applies refills only after it has computed that cycle's expected outcome, so the lookup must report the state from before the refill and see the new translation one cycle later. The flush-with-refill collision is judged the same way: the lookups that follow must all miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic dty;
    logic usr;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PPN_W       = 20,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [VPN_W-1:0]       wr_vpn_i,
  input  logic [PPN_W-1:0]       wr_ppn_i,
  input  tlb_perm_t              wr_perm_i,
  input  logic [VPN_W-1:0]       lk_vpn_i,
  output logic [NUM_ENTRIES-1:0] lk_match_o,
  output logic [PPN_W-1:0]       lk_ppn_o,
  output tlb_perm_t              lk_perm_o,
  output logic [NUM_ENTRIES-1:0] rf_match_o
);
  logic [NUM_ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]       vpn_q  [NUM_ENTRIES];
  logic [PPN_W-1:0]       ppn_q  [NUM_ENTRIES];
  tlb_perm_t              perm_q [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx_i]  <= 1'b1;
      vpn_q[wr_idx_i]  <= wr_vpn_i;
      ppn_q[wr_idx_i]  <= wr_ppn_i;
      perm_q[wr_idx_i] <= wr_perm_i;
    end
  end

  // two compare ports: one for lookup, one for refill deduplication
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign lk_match_o[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i);
    assign rf_match_o[g] = vld_q[g] && (vpn_q[g] == wr_vpn_i);
  end

  // one-hot AND-OR read mux
  always_comb begin
    lk_ppn_o  = '0;
    lk_perm_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lk_match_o[i]) begin
        lk_ppn_o  = lk_ppn_o | ppn_q[i];
        lk_perm_o = tlb_perm_t'(lk_perm_o | perm_q[i]);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter bit          USE_FIFO    = 1'b1,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  if (USE_FIFO) begin : g_fifo
    logic [IDX_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ptr_q <= '0;
      else if (flush_i) ptr_q <= '0;
      else if (adv_i)
        ptr_q <= (ptr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
    assign idx_o = ptr_q;
  end else begin : g_lfsr
    localparam logic [15:0] SEED = 16'hACE1;
    logic [15:0] lfsr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lfsr_q <= SEED;
      else if (flush_i) lfsr_q <= SEED;
      else if (adv_i)
        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end
    assign idx_o = IDX_W'(lfsr_q % 16'(NUM_ENTRIES));
  end
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  logic      match_i,
  input  tlb_perm_t perm_i,
  input  logic      write_i,
  input  logic      user_i,
  output logic      prot_o,
  output logic      dirty_o
);
  logic kind_ok, mode_ok;
  assign kind_ok = write_i ? perm_i.wr : perm_i.rd;
  assign mode_ok = !user_i || perm_i.usr;
  assign prot_o  = match_i && !(kind_ok && mode_ok);
  // only reached when the write is otherwise legal
  assign dirty_o = match_i && !prot_o && write_i && !perm_i.dty;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PPN_W       = 20,
  parameter int unsigned OFS_W       = 12,
  parameter bit          USE_FIFO    = 1'b1,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned VA_W       = VPN_W + OFS_W,
  localparam int unsigned PA_W       = PPN_W + OFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lk_valid_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  input  logic             lk_write_i,
  input  logic             lk_user_i,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic             lk_prot_fault_o,
  output logic             lk_dirty_fault_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  input  logic             rf_valid_i,
  input  logic [VPN_W-1:0] rf_vpn_i,
  input  logic [PPN_W-1:0] rf_ppn_i,
  input  logic             rf_rd_i,
  input  logic             rf_wr_i,
  input  logic             rf_dirty_i,
  input  logic             rf_user_i
);
  logic [NUM_ENTRIES-1:0] lk_match, rf_match;
  logic [PPN_W-1:0]       lk_ppn;
  tlb_perm_t              lk_perm, rf_perm;
  logic                   any_match, prot, dirty;
  logic                   rf_present, wr_en, adv;
  logic [IDX_W-1:0]       victim_idx, hit_idx, wr_idx;

  assign rf_perm = '{rd: rf_rd_i, wr: rf_wr_i, dty: rf_dirty_i, usr: rf_user_i};

  tlb_cam #(
    .NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_cam (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_vpn_i   (rf_vpn_i),
    .wr_ppn_i   (rf_ppn_i),
    .wr_perm_i  (rf_perm),
    .lk_vpn_i   (lk_vaddr_i[VA_W-1:OFS_W]),
    .lk_match_o (lk_match),
    .lk_ppn_o   (lk_ppn),
    .lk_perm_o  (lk_perm),
    .rf_match_o (rf_match)
  );

  tlb_victim #(
    .NUM_ENTRIES(NUM_ENTRIES), .USE_FIFO(USE_FIFO)
  ) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .adv_i   (adv),
    .idx_o   (victim_idx)
  );

  assign any_match = lk_valid_i && (|lk_match);

  tlb_perm_chk u_perm (
    .match_i (any_match),
    .perm_i  (lk_perm),
    .write_i (lk_write_i),
    .user_i  (lk_user_i),
    .prot_o  (prot),
    .dirty_o (dirty)
  );

  assign lk_hit_o         = any_match && !prot && !dirty;
  assign lk_miss_o        = lk_valid_i && !(|lk_match);
  assign lk_prot_fault_o  = prot;
  assign lk_dirty_fault_o = dirty;
  assign lk_paddr_o       = lk_hit_o ? {lk_ppn, lk_vaddr_i[OFS_W-1:0]} : '0;

  // refill: overwrite a present page in place, else take the victim slot
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (rf_match[i]) hit_idx = IDX_W'(i);
  end

  assign rf_present = |rf_match;
  assign wr_en      = rf_valid_i && !flush_i;
  assign wr_idx     = rf_present ? hit_idx : victim_idx;
  assign adv        = wr_en && !rf_present;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned OFS_W       = 12,
  parameter int unsigned PA_W        = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flush_i,
  input logic                   lk_valid_i,
  input logic [VPN_W+OFS_W-1:0] lk_vaddr_i,
  input logic                   lk_write_i,
  input logic                   lk_hit_o,
  input logic                   lk_miss_o,
  input logic                   lk_prot_fault_o,
  input logic                   lk_dirty_fault_o,
  input logic [PA_W-1:0]        lk_paddr_o,
  input logic                   rf_valid_i,
  input logic [VPN_W-1:0]       rf_vpn_i,
  input logic [NUM_ENTRIES-1:0] lk_match
);
  logic [3:0] outc;
  assign outc = {lk_hit_o, lk_miss_o, lk_prot_fault_o, lk_dirty_fault_o};

  a_r11_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(outc));
  a_r11_unique_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> (outc == 4'b0000));
  a_r3_miss_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |-> (lk_paddr_o == '0));
  a_r6_dirty_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_dirty_fault_o |-> lk_write_i);
  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !(lk_hit_o || lk_prot_fault_o || lk_dirty_fault_o));
  a_r10_refill_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_valid_i && !flush_i) |=>
      !(lk_valid_i && lk_vaddr_i[VPN_W+OFS_W-1:OFS_W] == $past(rf_vpn_i) && lk_miss_o));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .OFS_W(OFS_W), .PA_W(PA_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .flush_i          (flush_i),
  .lk_valid_i       (lk_valid_i),
  .lk_vaddr_i       (lk_vaddr_i),
  .lk_write_i       (lk_write_i),
  .lk_hit_o         (lk_hit_o),
  .lk_miss_o        (lk_miss_o),
  .lk_prot_fault_o  (lk_prot_fault_o),
  .lk_dirty_fault_o (lk_dirty_fault_o),
  .lk_paddr_o       (lk_paddr_o),
  .rf_valid_i       (rf_valid_i),
  .rf_vpn_i         (rf_vpn_i),
  .lk_match         (lk_match)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
  localparam int N     = 32;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int OFS_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0;
  logic lk_valid_i = 1'b0, lk_write_i = 1'b0, lk_user_i = 1'b0;
  logic [VPN_W+OFS_W-1:0] lk_vaddr_i = '0;
  logic lk_hit_o, lk_miss_o, lk_prot_fault_o, lk_dirty_fault_o;
  logic [PPN_W+OFS_W-1:0] lk_paddr_o;
  logic rf_valid_i = 1'b0;
  logic [VPN_W-1:0] rf_vpn_i = '0;
  logic [PPN_W-1:0] rf_ppn_i = '0;
  logic rf_rd_i = 1'b0, rf_wr_i = 1'b0, rf_dirty_i = 1'b0, rf_user_i = 1'b0;

  always #2.5 clk = ~clk;

  tlb_xlate u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i), .lk_write_i(lk_write_i),
    .lk_user_i(lk_user_i), .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o),
    .lk_prot_fault_o(lk_prot_fault_o), .lk_dirty_fault_o(lk_dirty_fault_o),
    .lk_paddr_o(lk_paddr_o), .rf_valid_i(rf_valid_i), .rf_vpn_i(rf_vpn_i),
    .rf_ppn_i(rf_ppn_i), .rf_rd_i(rf_rd_i), .rf_wr_i(rf_wr_i),
    .rf_dirty_i(rf_dirty_i), .rf_user_i(rf_user_i)
  );

  // behavioural reference
  bit          m_v [N];
  int unsigned m_vpn [N];
  int unsigned m_ppn [N];
  bit          m_r [N], m_w [N], m_d [N], m_u [N];
  int          m_ptr;
  int          vectors = 0, errors = 0;
  bit          done = 1'b0;

  function automatic void model_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
  endfunction

  task automatic cmp(string tag, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare before the edge, then advance the model
  task automatic step(string tag, bit lv, int unsigned vpn, int unsigned ofs,
                      bit wr, bit usr, bit rv, int unsigned rvpn, int unsigned rppn,
                      bit rr, bit rw, bit rd, bit ru, bit fl);
    int  idx;
    bit  e_hit, e_miss, e_prot, e_dty;
    longint e_pa;
    lk_valid_i = lv; lk_vaddr_i = {VPN_W'(vpn), OFS_W'(ofs)};
    lk_write_i = wr; lk_user_i = usr;
    rf_valid_i = rv; rf_vpn_i = VPN_W'(rvpn); rf_ppn_i = PPN_W'(rppn);
    rf_rd_i = rr; rf_wr_i = rw; rf_dirty_i = rd; rf_user_i = ru;
    flush_i = fl;
    #1;
    idx = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) idx = i;
    e_hit = 0; e_miss = 0; e_prot = 0; e_dty = 0; e_pa = 0;
    if (lv) begin
      if (idx < 0) e_miss = 1;
      else begin
        e_prot = (wr ? !m_w[idx] : !m_r[idx]) || (usr && !m_u[idx]);
        e_dty  = !e_prot && wr && !m_d[idx];
        e_hit  = !e_prot && !e_dty;
        if (e_hit) e_pa = (longint'(m_ppn[idx]) << OFS_W) | longint'(ofs);
      end
    end
    cmp({tag, "/R2"}, "hit", lk_hit_o, e_hit);
    cmp({tag, "/R2"}, "paddr", lk_paddr_o, e_pa);
    cmp({tag, "/R3"}, "miss", lk_miss_o, e_miss);
    cmp({tag, "/R4"}, "prot", lk_prot_fault_o, e_prot);
    cmp({tag, "/R6"}, "dirty", lk_dirty_fault_o, e_dty);
    @(posedge clk);
    if (fl) model_clear();
    else if (rv) begin
      idx = -1;
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == rvpn) idx = i;
      if (idx < 0) begin idx = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_v[idx] = 1; m_vpn[idx] = rvpn; m_ppn[idx] = rppn;
      m_r[idx] = rr; m_w[idx] = rw; m_d[idx] = rd; m_u[idx] = ru;
    end
    @(negedge clk);
  endtask

  task automatic look(string tag, int unsigned vpn, int unsigned ofs, bit wr, bit usr);
    step(tag, 1, vpn, ofs, wr, usr, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string tag, int unsigned vpn, int unsigned ppn, bit r, bit w, bit d, bit u);
    step(tag, 0, 0, 0, 0, 0, 1, vpn, ppn, r, w, d, u, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    look("R1", 20'h00010, 12'h000, 0, 0);
    look("R1", 20'h00000, 12'h123, 1, 1);
    step("R3", 0, 20'h00010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: first fills land in slots 0..3
    fill("R8", 20'h00010, 20'hABCDE, 1, 1, 1, 1);
    fill("R8", 20'h00020, 20'h11111, 1, 0, 0, 1);
    fill("R8", 20'h00030, 20'h22222, 1, 1, 0, 1);
    fill("R8", 20'h00040, 20'h33333, 1, 1, 1, 0);
    // R2: hits with offset pass-through
    look("R2", 20'h00010, 12'hFFF, 0, 1);
    look("R2", 20'h00010, 12'h001, 1, 1);
    look("R2", 20'h00030, 12'h7A5, 0, 0);
    // R4: write to read-only page
    look("R4", 20'h00020, 12'h010, 1, 0);
    look("R4", 20'h00020, 12'h010, 0, 1);
    // R5: user touching kernel page, kernel allowed
    look("R5", 20'h00040, 12'h044, 0, 1);
    look("R5", 20'h00040, 12'h044, 1, 0);
    // R6: clean writable page, and precedence of protection
    look("R6", 20'h00030, 12'h100, 1, 0);
    fill("R6", 20'h00050, 20'h44444, 1, 1, 0, 0);
    look("R6", 20'h00050, 12'h100, 1, 1);
    // R10: refill and lookup of the same page in one cycle
    step("R10", 1, 20'h00060, 12'h0AA, 0, 0, 1, 20'h00060, 20'h55555, 1, 0, 0, 1, 0);
    look("R10", 20'h00060, 12'h0AA, 0, 0);
    step("R10", 1, 20'h00020, 12'h0AA, 1, 0, 1, 20'h00020, 20'h66666, 1, 1, 1, 1, 0);
    // R7: overwrite in place, then pointer order unaffected
    look("R7", 20'h00020, 12'h0AB, 1, 1);
    fill("R7", 20'h00030, 20'h77777, 1, 1, 1, 1);
    look("R7", 20'h00030, 12'h222, 1, 1);
    // R9: flush, then a flush colliding with a refill
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    look("R9", 20'h00010, 12'h000, 0, 0);
    fill("R9", 20'h00070, 20'h88888, 1, 1, 1, 1);
    step("R9", 0, 0, 0, 0, 0, 1, 20'h00080, 20'h99999, 1, 1, 1, 1, 1);
    look("R9", 20'h00070, 12'h000, 0, 0);
    look("R9", 20'h00080, 12'h000, 0, 0);
    // R8: N+1 distinct fills evict the first
    for (int k = 0; k <= N; k++) fill("R8", 20'h01000 + k, 20'h20000 + k, 1, 1, 1, 1);
    look("R8", 20'h01000, 12'h000, 0, 0);
    look("R8", 20'h01001, 12'h000, 0, 0);
    look("R8", 20'h01000 + N, 12'h000, 0, 0);
    // R11: mixed random traffic from a small pool
    for (int k = 0; k < 3000; k++) begin
      bit fl;
      fl = ($urandom % 97) == 0;
      step("R11", $urandom % 2 == 0, $urandom % 48, $urandom % 4096,
           $urandom % 2 == 0, $urandom % 2 == 0, $urandom % 3 == 0,
           $urandom % 48, $urandom % 1048576,
           $urandom % 4 != 0, $urandom % 2 == 0, $urandom % 2 == 0, $urandom % 2 == 0, fl);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule